// File: doc/BRIEF.md
# SDIO Single-Byte Direct Command Responder

This block answers single-byte direct register commands on the card side of an SDIO link. Upstream logic has already taken the command off the line and checked it. That logic presents the 32-bit argument together with a one-cycle valid strobe. The block decodes the argument, carries out the access, and returns one response byte with a one-cycle valid pulse on the following clock.

Function 0 holds a small common register set. It has two fixed status bytes, a speed-capability byte and a writable block-size byte. Function 1 holds a backplane window base. Its three upper bytes are loaded through three neighbouring addresses, and a clock-status address reports that both the low-power and the high-throughput clocks are available. The block drives the full 32-bit window base continuously so that backplane access logic can add it to burst addresses.

Top module: `sdio_direct_responder`

## Requirements
- R1: The argument is decoded as: bit 31 write flag (1 = write), bits 30:28 function number, bits 25:9 a 17-bit register address, bits 7:0 data byte. Bits 27:26 and bit 8 have no effect.
- R2: A read of function 0 address 0x02 returns 0x02, and a read of function 0 address 0x03 returns 0x02.
- R3: Function 0 address 0x10 is a block-size byte. A write stores the data byte, a read returns the stored byte, and the reset value is 0x00.
- R4: A read of function 0 address 0x13 returns 0x01.
- R5: Any access to function 1, read or write, loads the data byte into one byte of `windowBase`: address 0x1000A loads bits 15:8, 0x1000B loads bits 23:16 and 0x1000C loads bits 31:24. All other bits keep their value. Bits 7:0 are always 0, and the reset value is 0.
- R6: A read of function 1 address 0x1000E returns 0xC0.
- R7: A read of any other function or address returns 0x00, and so does a read of a window address. Every write returns 0x00. A write to an address that R3 and R5 do not name changes no state.
- R8: `respValid` is high for exactly the cycle after each cycle in which `cmdValid` is high, and low otherwise. Commands on consecutive cycles give consecutive pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command argument is valid this cycle |
| cmdArg | input | 32 | Direct command argument word |
| respValid | output | 1 | Response byte is valid this cycle |
| respData | output | 8 | Response byte; holds between commands |
| windowBase | output | 32 | Current backplane window base |

## Verification
A wrong internal state shows up at the ports in two ways. A corrupted window byte appears on `windowBase` at the first edge after the faulty load. A corrupted block-size byte stays hidden until the next function-0 read of address 0x10, and it then appears on `respData` one cycle after that read. The bench therefore checks `windowBase` after every command and reads the block size back immediately after each write. It sweeps all eight function numbers over both mapped and unmapped addresses, so a decode that is wrong in one field shows up as a wrong response byte or an unexpected window change.

// File: rtl/sdio_dr_pkg.sv
package sdio_dr_pkg;
  localparam int ARG_W     = 32;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 17;
  localparam int FN_W      = 3;
  localparam int WIN_BYTES = 3;
  localparam int WIN_W     = (WIN_BYTES + 1) * DATA_W;

  // argument field positions
  localparam int WR_BIT  = 31;
  localparam int FN_LO   = 28;
  localparam int ADDR_LO = 9;

  localparam logic [FN_W-1:0] FN_COMMON    = 3'd0;
  localparam logic [FN_W-1:0] FN_BACKPLANE = 3'd1;

  localparam logic [ADDR_W-1:0] ADR_IO_ON    = 17'h00002;
  localparam logic [ADDR_W-1:0] ADR_IO_RDY   = 17'h00003;
  localparam logic [ADDR_W-1:0] ADR_BLK      = 17'h00010;
  localparam logic [ADDR_W-1:0] ADR_SPEED    = 17'h00013;
  localparam logic [ADDR_W-1:0] ADR_WIN_BASE = 17'h1000A;
  localparam logic [ADDR_W-1:0] ADR_CLK_STAT = 17'h1000E;

  localparam logic [DATA_W-1:0] VAL_FN_BITS = 8'h02;
  localparam logic [DATA_W-1:0] VAL_HISPEED = 8'h01;
  localparam logic [DATA_W-1:0] VAL_CLK_OK  = 8'hC0;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_FN_BITS, SEL_BLK, SEL_HISPEED, SEL_CLK_OK
  } rdSel_e;

  typedef struct packed {
    logic                  accept;
    logic                  ldBlk;
    logic [WIN_BYTES-1:0]  ldWin;
    rdSel_e                sel;
    logic [DATA_W-1:0]     wrData;
  } ctl_t;
endpackage

// File: rtl/sdio_dr_ctrl.sv
module sdio_dr_ctrl
  import sdio_dr_pkg::*;
(
  input  logic             cmdValid,
  input  logic [ARG_W-1:0] cmdArg,
  output ctl_t             ctl
);
  logic              isWrite;
  logic [FN_W-1:0]   fnNum;
  logic [ADDR_W-1:0] regAddr;

  assign isWrite = cmdArg[WR_BIT];
  assign fnNum   = cmdArg[FN_LO +: FN_W];
  assign regAddr = cmdArg[ADDR_LO +: ADDR_W];

  always_comb begin
    ctl        = '0;
    ctl.sel    = SEL_ZERO;
    ctl.wrData = cmdArg[DATA_W-1:0];
    if (cmdValid) begin
      ctl.accept = 1'b1;
      if (fnNum == FN_COMMON) begin
        if (regAddr == ADR_IO_ON || regAddr == ADR_IO_RDY) begin
          if (!isWrite) ctl.sel = SEL_FN_BITS;
        end else if (regAddr == ADR_BLK) begin
          if (isWrite) ctl.ldBlk = 1'b1;
          else         ctl.sel   = SEL_BLK;
        end else if (regAddr == ADR_SPEED) begin
          if (!isWrite) ctl.sel = SEL_HISPEED;
        end
      end else if (fnNum == FN_BACKPLANE) begin
        for (int i = 0; i < WIN_BYTES; i++) begin
          if (regAddr == ADR_WIN_BASE + ADDR_W'(i)) ctl.ldWin[i] = 1'b1;
        end
        if (regAddr == ADR_CLK_STAT && !isWrite) ctl.sel = SEL_CLK_OK;
      end
    end
  end
endmodule

// File: rtl/sdio_dr_datapath.sv
module sdio_dr_datapath
  import sdio_dr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  output logic [WIN_W-1:0]  windowBase
);
  logic [DATA_W-1:0]                blkSize;
  logic [WIN_BYTES-1:0][DATA_W-1:0] winReg;
  logic [DATA_W-1:0]                rdVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          blkSize <= '0;
    else if (ctl.ldBlk) blkSize <= ctl.wrData;
  end

  for (genvar g = 0; g < WIN_BYTES; g++) begin : gWin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             winReg[g] <= '0;
      else if (ctl.ldWin[g]) winReg[g] <= ctl.wrData;
    end
  end

  assign windowBase = {winReg, {DATA_W{1'b0}}};

  always_comb begin
    case (ctl.sel)
      SEL_FN_BITS: rdVal = VAL_FN_BITS;
      SEL_BLK:     rdVal = blkSize;
      SEL_HISPEED: rdVal = VAL_HISPEED;
      SEL_CLK_OK:  rdVal = VAL_CLK_OK;
      default:     rdVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respData  <= '0;
    end else begin
      respValid <= ctl.accept;
      if (ctl.accept) respData <= rdVal;
    end
  end

  assert_blk_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.ldBlk |=> $stable(blkSize));
  assert_win_mid_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldWin[1] |=> windowBase[23:16] == $past(ctl.wrData));
  assert_one_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.ldBlk, ctl.ldWin}));
endmodule

// File: rtl/sdio_direct_responder.sv
module sdio_direct_responder
  import sdio_dr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [31:0] cmdArg,
  output logic        respValid,
  output logic [7:0]  respData,
  output logic [31:0] windowBase
);
  ctl_t ctl;

  sdio_dr_ctrl uCtrl (
    .cmdValid (cmdValid),
    .cmdArg   (cmdArg),
    .ctl      (ctl)
  );

  sdio_dr_datapath uData (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .respValid  (respValid),
    .respData   (respData),
    .windowBase (windowBase)
  );

  assert_resp_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> respValid);
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !respValid);
  assert_write_resp_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdArg[WR_BIT]) |=> respData == 8'h00);
  assert_clk_status_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdArg[WR_BIT] && cmdArg[30:28] == FN_BACKPLANE
     && cmdArg[25:9] == ADR_CLK_STAT) |=> respData == VAL_CLK_OK);
  assert_idle_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> $stable(windowBase));
endmodule

// File: tb/sdio_direct_responder_test.sv
`timescale 1ns/1ps
module sdio_direct_responder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [31:0] cmdArg = '0;
  logic        respValid;
  logic [7:0]  respData;
  logic [31:0] windowBase;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0]  blkModel = 8'h00;
  logic [31:0] winModel = 32'h0;

  always #2.5 clk = ~clk;

  sdio_direct_responder uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdArg(cmdArg),
    .respValid(respValid), .respData(respData), .windowBase(windowBase)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkArg(input logic wr, input logic [2:0] fn,
                                        input logic [16:0] adr, input logic [7:0] dat);
    // bits 27:26 and 8 set as noise (R1: no effect)
    return {wr, fn, 2'b11, adr, 1'b1, dat};
  endfunction

  function automatic string reqFor(input logic [2:0] fn, input logic [16:0] adr);
    if (fn == 0 && (adr == 17'h2 || adr == 17'h3)) return "R2";
    if (fn == 0 && adr == 17'h10) return "R3";
    if (fn == 0 && adr == 17'h13) return "R4";
    if (fn == 1 && adr >= 17'h1000A && adr <= 17'h1000C) return "R5";
    if (fn == 1 && adr == 17'h1000E) return "R6";
    return "R7";
  endfunction

  // model: returns expected response and updates model state
  function automatic logic [7:0] model(input logic wr, input logic [2:0] fn,
                                       input logic [16:0] adr, input logic [7:0] dat);
    logic [7:0] r = 8'h00;
    if (fn == 0) begin
      if (!wr && (adr == 17'h2 || adr == 17'h3)) r = 8'h02;
      if (adr == 17'h10) begin
        if (wr) blkModel = dat; else r = blkModel;
      end
      if (!wr && adr == 17'h13) r = 8'h01;
    end else if (fn == 1) begin
      if (adr == 17'h1000A) winModel[15:8]  = dat;
      if (adr == 17'h1000B) winModel[23:16] = dat;
      if (adr == 17'h1000C) winModel[31:24] = dat;
      if (!wr && adr == 17'h1000E) r = 8'hC0;
    end
    return r;
  endfunction

  task automatic access(input logic wr, input logic [2:0] fn,
                        input logic [16:0] adr, input logic [7:0] dat);
    logic [7:0] exp;
    string tag;
    tag = reqFor(fn, adr);
    exp = model(wr, fn, adr, dat);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdArg   = mkArg(wr, fn, adr, dat);
    @(negedge clk);
    cmdValid = 1'b0;
    cmdArg   = '0;
    check("R8 valid", {31'b0, respValid}, 32'd1);
    check(tag, {24'b0, respData}, {24'b0, exp});
    check(fn == 1 ? "R5 window" : "R7 window", windowBase, winModel);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    logic [16:0] adrList [14];
    logic [7:0]  e1, e2;
    adrList = '{17'h0, 17'h1, 17'h2, 17'h3, 17'h10, 17'h13, 17'h1000A,
                17'h1000B, 17'h1000C, 17'h1000D, 17'h1000E, 17'h10010,
                17'h10002, 17'h1FFFF};
    repeat (3) @(negedge clk);
    check("R8 reset valid", {31'b0, respValid}, 32'd0);
    check("R5 reset window", windowBase, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 idle valid", {31'b0, respValid}, 32'd0);
    access(1'b0, 3'd0, 17'h10, 8'h5A);  // R3 reset value read

    // sweep all functions over mapped and unmapped addresses (R1, R2, R4, R6, R7)
    for (int f = 0; f < 8; f++) begin
      for (int a = 0; a < 14; a++) begin
        access(1'b0, 3'(f), adrList[a], 8'(f * 37 + a * 11));
        access(1'b1, 3'(f), adrList[a], 8'(f * 53 + a * 7 + 1));
        access(1'b0, 3'd0, 17'h10, 8'h00); // R3 / R7: block size untouched or stored
      end
    end

    // R3: every block-size value written and read back
    for (int v = 0; v < 256; v++) begin
      access(1'b1, 3'd0, 17'h10, 8'(v));
      access(1'b0, 3'd0, 17'h10, 8'(~v));
    end

    // R5: each window byte loaded with a spread of values
    for (int b = 0; b < 3; b++) begin
      for (int v = 0; v < 256; v += 17) begin
        access(v[0], 3'd1, 17'h1000A + 17'(b), 8'(v ^ (b * 85)));
        check("R5 low byte zero", {24'b0, windowBase[7:0]}, 32'h0);
      end
    end

    // R8: back-to-back commands give back-to-back pulses
    e1 = model(1'b0, 3'd1, 17'h1000E, 8'h00);
    e2 = model(1'b0, 3'd0, 17'h13, 8'h00);
    @(negedge clk);
    cmdValid = 1'b1; cmdArg = mkArg(1'b0, 3'd1, 17'h1000E, 8'h00);
    @(negedge clk);
    check("R8 first pulse", {31'b0, respValid}, 32'd1);
    check("R6 back-to-back", {24'b0, respData}, {24'b0, e1});
    cmdArg = mkArg(1'b0, 3'd0, 17'h13, 8'h00);
    @(negedge clk);
    cmdValid = 1'b0; cmdArg = '0;
    check("R8 second pulse", {31'b0, respValid}, 32'd1);
    check("R4 back-to-back", {24'b0, respData}, {24'b0, e2});
    @(negedge clk);
    check("R8 pulse ends", {31'b0, respValid}, 32'd0);
    check("R8 data holds", {24'b0, respData}, {24'b0, e2});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule